// File: doc/BRIEF.md
# Three-Level Interrupt Enable and Vector Controller

This block sits between the interrupt request lines of several peripheral modules and the instruction sequencer of a small processor. Each module has a group of request lines. Every line is qualified by a local enable that belongs to its module. The qualified lines of a module are ORed into one module request. That module request is then qualified by a module mask bit. A global enable bit gates the result once more. When the sequencer signals an instruction boundary and a qualified request exists, the block raises a one-cycle interrupt-taken strobe. In the same step it clears the global enable, so the handler is not re-entered until software sets the bit again.

The handler address is a 16-bit vector register, which is always visible on an output. Software writes registers through an 8-bit write port. A vector write supplies only the low byte. The high byte comes from a prefix register that the write immediately before it may have loaded. If there was no such prefix write, the high byte is 00h, so handlers in the range 0000h to 00FFh need a single write. The prefix is used up by the next register write of any kind.

Top module: `irq_enable_ctrl`

## Requirements
- R1: After reset the vector output is 0000h and the taken strobe is 0. The global enable, the mask bits and all local enables are 0, so a request at a boundary is not taken until software enables it.
- R2: A write with select 0 loads the prefix byte. A write with select 1 that directly follows it sets the vector to {prefix, data}, and the new vector is visible in the cycle after the write.
- R3: A vector write (select 1) with no prefix write directly before it sets the vector high byte to 00h. Any other register write between the prefix write and the vector write also discards the prefix.
- R4: While the global enable (select 2, data bit 0) is 0, no request is taken.
- R5: Module m's request is taken only if mask bit m is 1 (select 3, data bit m).
- R6: Source s of module m counts only while local enable bit s of module m is 1. These enables are written with select 4, index m and data bit s. Request line number m*SRCS+s is source s of module m.
- R7: The taken strobe is high for exactly the cycle after a boundary cycle in which the global enable is 1 and at least one enabled source of an unmasked module is pending. Without a boundary, nothing is taken.
- R8: Taking an interrupt clears the global enable, even if the control register is written in that same cycle. No further interrupt is taken until software sets the enable again.
- R9: A module request is the OR of that module's locally enabled pending sources. One such source, in any unmasked module, is enough.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | MODS*SRCS | Pending request lines; line m*SRCS+s is source s of module m |
| insn_boundary | input | 1 | High in a cycle where an interrupt may be taken |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | 0 prefix, 1 vector low byte, 2 control, 3 module mask, 4 local enables |
| wr_idx | input | IDX_W | Module index for local-enable writes |
| wr_data | input | 8 | Write data |
| irq_taken | output | 1 | One-cycle interrupt-taken strobe |
| irq_vector | output | 16 | Handler address |

## Verification
Two situations are hardest to reach from the ports. The first is a take that collides with a software write of the control register. The second is a prefix that goes stale because an unrelated write came between it and the vector write. The bench drives the control write and the boundary in the same cycle. It then shows at the next boundary that the enable stayed cleared. It also places a mask write between a prefix write and a vector write, and reads the vector output back. A table of enable combinations checks each level of qualification. Each combination moves one enable bit or request line against the others.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
    typedef enum logic [2:0] {
        SEL_PREFIX  = 3'd0,
        SEL_VECTOR  = 3'd1,
        SEL_CONTROL = 3'd2,
        SEL_MASK    = 3'd3,
        SEL_LOCAL   = 3'd4
    } reg_sel_e;

    localparam int GIE_BIT = 0;
endpackage

// File: rtl/irq_source_group.sv
module irq_source_group #(
    parameter int SRCS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            loc_wr,
    input  logic [7:0]      wr_data,
    input  logic [SRCS-1:0] src_req,
    output logic            mod_req
);
    typedef struct packed {
        logic [SRCS-1:0] loc_en;
    } grp_state_t;

    grp_state_t st_d, st_q;
    logic [SRCS-1:0] qual;

    always_comb begin
        st_d = st_q;
        if (loc_wr) st_d.loc_en = wr_data[SRCS-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    genvar s;
    generate
        for (s = 0; s < SRCS; s++) begin : g_qual
            assign qual[s] = src_req[s] & st_q.loc_en[s];
        end
    endgenerate

    assign mod_req = |qual;

    // R6
    local_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.loc_en == '0) |-> !mod_req);
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_ctrl_pkg::*;
#(
    parameter int MODS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [2:0]      wr_sel,
    input  logic [7:0]      wr_data,
    input  logic            clr_gie,
    output logic            gie,
    output logic [MODS-1:0] mod_mask,
    output logic [15:0]     vector
);
    typedef struct packed {
        logic [7:0]      prefix;
        logic [15:0]     vec;
        logic            gie;
        logic [MODS-1:0] mask;
    } rf_state_t;

    rf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.prefix = 8'h00;
            unique case (reg_sel_e'(wr_sel))
                SEL_PREFIX:  st_d.prefix = wr_data;
                SEL_VECTOR:  st_d.vec    = {st_q.prefix, wr_data};
                SEL_CONTROL: st_d.gie    = wr_data[GIE_BIT];
                SEL_MASK:    st_d.mask   = wr_data[MODS-1:0];
                default:     ;
            endcase
        end
        if (clr_gie) st_d.gie = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gie      = st_q.gie;
    assign mod_mask = st_q.mask;
    assign vector   = st_q.vec;

    // R3
    vec_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd1 && $past(!(wr_en && wr_sel == 3'd0)))
        |=> vector[15:8] == 8'h00);
    // R2
    vec_low_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd1) |=> vector[7:0] == $past(wr_data));
endmodule

// File: rtl/irq_enable_ctrl.sv
module irq_enable_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int MODS  = 4,
    parameter int SRCS  = 4,
    parameter int IDX_W = (MODS > 1) ? $clog2(MODS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [MODS*SRCS-1:0] irq_req,
    input  logic                 insn_boundary,
    input  logic                 wr_en,
    input  logic [2:0]           wr_sel,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [7:0]           wr_data,
    output logic                 irq_taken,
    output logic [15:0]          irq_vector
);
    localparam int NREQ = MODS * SRCS;

    typedef struct packed {
        logic taken;
    } top_state_t;

    top_state_t st_d, st_q;
    logic [MODS-1:0] mod_req;
    logic [MODS-1:0] mod_mask;
    logic            gie;
    logic            take_now;

    irq_regfile #(.MODS(MODS)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .clr_gie  (take_now),
        .gie      (gie),
        .mod_mask (mod_mask),
        .vector   (irq_vector)
    );

    genvar m;
    generate
        for (m = 0; m < MODS; m++) begin : g_mod
            logic loc_wr;
            assign loc_wr = wr_en && (wr_sel == 3'd4) && (wr_idx == IDX_W'(m));
            irq_source_group #(.SRCS(SRCS)) i_grp (
                .clk     (clk),
                .rst_n   (rst_n),
                .loc_wr  (loc_wr),
                .wr_data (wr_data),
                .src_req (irq_req[m*SRCS +: SRCS]),
                .mod_req (mod_req[m])
            );
        end
    endgenerate

    always_comb begin
        take_now = insn_boundary && gie && |(mod_req & mod_mask);
        st_d       = st_q;
        st_d.taken = take_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_taken = st_q.taken;

    // R7
    take_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken |-> $past(insn_boundary));
    // R4
    take_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken |-> $past(gie));
    // R8
    gie_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken |-> !gie);
    // R5
    take_needs_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken |-> $past(|(mod_req & mod_mask)));
    // R9
    req_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req[NREQ-1:0] == '0) |=> !irq_taken);
endmodule

// File: tb/test_irq_enable_ctrl.sv
module test_irq_enable_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int MODS = 4;
    localparam int SRCS = 4;
    localparam int IDX_W = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_req = '0;
    logic        insn_boundary = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [IDX_W-1:0] wr_idx = '0;
    logic [7:0]  wr_data = '0;
    logic        irq_taken;
    logic [15:0] irq_vector;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_enable_ctrl #(.MODS(MODS), .SRCS(SRCS)) i_irq_enable_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .insn_boundary(insn_boundary),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx), .wr_data(wr_data),
        .irq_taken(irq_taken), .irq_vector(irq_vector)
    );

    // gie, mask, local enables, request, boundary, expected take
    typedef struct packed {
        logic        gie;
        logic [3:0]  mask;
        logic [15:0] loc;
        logic [15:0] req;
        logic        bnd;
        logic        exp;
    } row_t;

    localparam row_t TABLE [10] = '{
        '{1'b1, 4'b0001, 16'h000F, 16'h0001, 1'b1, 1'b1}, // R9 single source
        '{1'b0, 4'b0001, 16'h000F, 16'h0001, 1'b1, 1'b0}, // R4 global off
        '{1'b1, 4'b0000, 16'h000F, 16'h0001, 1'b1, 1'b0}, // R5 masked
        '{1'b1, 4'b0001, 16'h0000, 16'h0001, 1'b1, 1'b0}, // R6 local off
        '{1'b1, 4'b1111, 16'hFFFF, 16'h0000, 1'b1, 1'b0}, // R7 nothing pending
        '{1'b1, 4'b1000, 16'hF000, 16'h8000, 1'b1, 1'b1}, // R9 top module
        '{1'b1, 4'b1111, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0}, // R7 no boundary
        '{1'b1, 4'b0100, 16'h0F00, 16'h0F00, 1'b1, 1'b1}, // R9 many sources
        '{1'b1, 4'b0010, 16'h00F0, 16'h000F, 1'b1, 1'b0}, // R5 request of masked module
        '{1'b1, 4'b0010, 16'h0020, 16'h0010, 1'b1, 1'b0}  // R6 other source enabled
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [IDX_W-1:0] idx, input logic [7:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_idx = idx; wr_data = data;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic boundary(input logic [15:0] req, input logic bnd);
        irq_req = req; insn_boundary = bnd;
        tick();
        irq_req = '0; insn_boundary = 1'b0;
    endtask

    task automatic check(input string req_tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        // R1 reset state
        check("R1 vector", irq_vector, 16'h0000);
        check("R1 taken", {15'd0, irq_taken}, 16'h0000);
        boundary(16'hFFFF, 1'b1);
        check("R1 disabled after reset", {15'd0, irq_taken}, 16'h0000);

        // R2 prefix + low byte
        wr(3'd0, '0, 8'hA5);
        wr(3'd1, '0, 8'h3C);
        check("R2 vector", irq_vector, 16'hA53C);
        // R3 no prefix
        wr(3'd1, '0, 8'h77);
        check("R3 no prefix", irq_vector, 16'h0077);
        // R3 prefix discarded by an intervening write
        wr(3'd0, '0, 8'h12);
        wr(3'd3, '0, 8'h00);
        wr(3'd1, '0, 8'h34);
        check("R3 stale prefix", irq_vector, 16'h0034);

        // table of enable combinations
        foreach (TABLE[i]) begin
            wr(3'd3, '0, {4'd0, TABLE[i].mask});
            for (int m = 0; m < MODS; m++)
                wr(3'd4, IDX_W'(m), {4'd0, TABLE[i].loc[m*SRCS +: SRCS]});
            wr(3'd2, '0, {7'd0, TABLE[i].gie});
            boundary(TABLE[i].req, TABLE[i].bnd);
            check($sformatf("R4-row%0d R5 R6 R7 R9", i), {15'd0, irq_taken}, {15'd0, TABLE[i].exp});
            tick();
            check("R7 single-cycle strobe", {15'd0, irq_taken}, 16'h0000);
        end

        // R8 reentry blocked
        wr(3'd3, '0, 8'h01);
        wr(3'd4, '0, 8'h01);
        wr(3'd2, '0, 8'h01);
        boundary(16'h0001, 1'b1);
        check("R8 first take", {15'd0, irq_taken}, 16'h0001);
        boundary(16'h0001, 1'b1);
        check("R8 reentry blocked", {15'd0, irq_taken}, 16'h0000);
        wr(3'd2, '0, 8'h01);
        boundary(16'h0001, 1'b1);
        check("R8 re-enabled", {15'd0, irq_taken}, 16'h0001);
        // R8 take wins over a same-cycle control write
        wr(3'd2, '0, 8'h01);
        wr_en = 1'b1; wr_sel = 3'd2; wr_data = 8'h01;
        boundary(16'h0001, 1'b1);
        wr_en = 1'b0; wr_data = '0;
        check("R8 collide take", {15'd0, irq_taken}, 16'h0001);
        boundary(16'h0001, 1'b1);
        check("R8 collide cleared", {15'd0, irq_taken}, 16'h0000);
        check("R2 vector kept", irq_vector, 16'h0034);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule